// File: doc/BRIEF.md
# Timer Block Global Counter and Registers

This block holds the shared part of a memory-mapped multi-timer unit. It has a 32-bit main counter that advances by one on every cycle where the tick enable input is high and counting is switched on. Three 64-bit global registers sit in front of it: a synthesized read-only capabilities word, a general configuration word carrying the counting switch, and the main counter. The per-timer comparator slices elsewhere in the chip read the live count and the counting switch from this block. They also watch a one-cycle re-arm strobe, which tells them to reload their deadlines from the current count.

Register requests arrive one per cycle with a byte offset, a size of 4 or 8 bytes and write data. An 8-byte access covers a whole register. A 4-byte access selects the lower half at the register's base offset, or the upper half at base+4. Switching counting off freezes the count where it stands. Switching it on again continues from that value rather than from zero.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the configuration register reads 0, `count_o` is 0, `count_en_o` is 0 and `rearm_o` is 0.
- R2: The capabilities register is at offset 0x000. Its fields are: bits 7:0 = 1 (revision); bits 12:8 = number of timers minus one (8 timers by default gives 7); bit 13 = 0 (32-bit counter); bits 31:16 = the vendor parameter (default 0x1D0C); bits 63:32 = the tick period in femtoseconds (default 100,000,000). All other bits are 0.
- R3: While configuration bit 0 (count enable) is 1, the count rises by exactly one on each cycle with `tick_en` high, and it wraps from 0xFFFFFFFF to 0. While bit 0 is 0, the count holds its value whatever `tick_en` does.
- R4: Clearing bit 0 freezes the count, and setting it again resumes from the frozen value. `rearm_o` pulses high for one cycle in two cases: when bit 0 changes from 0 to 1, and when the counter is written while bit 0 is 1.
- R5: Configuration bit 1 (legacy routing) always reads 0, whatever is written to it. All other configuration bits are read/write.
- R6: An access is ignored when its size is not 4 or 8, or when its offset is not a multiple of its size. A read of such an access returns 0xFFFFFFFFFFFFFFFF.
- R7: A 4-byte write at base+4 changes only bits 63:32 of the register, taking the data from `req_wdata[31:0]`. A 4-byte write at base changes only bits 31:0. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 set to 0.
- R8: The main counter is at offset 0x0F0 and reads as the count zero-extended to 64 bits. A write merges the data into that zero-extended value and keeps only the low 32 bits. As a result, a write to the upper half alone leaves the count unchanged.
- R9: A read at an offset that matches no register (anything other than 0x000, 0x010 or 0x0F0 and their +4 halves) returns 0. A write to such an offset changes nothing.
- R10: Writes to the capabilities register have no effect.
- R11: A read request gives `rsp_valid` high in the next cycle, with data reflecting the state before that cycle's edge. A write request gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter step enable, one step per high cycle |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W (10) | Byte offset of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| count_o | output | 32 | Live main counter value |
| count_en_o | output | 1 | Counting switch (configuration bit 0) |
| rearm_o | output | 1 | One-cycle strobe telling timers to reload from the count |

## Verification
The assertions assume that at most one request arrives per cycle. They also assume that the request fields are stable and known whenever `req_valid` is high, and that `tick_en` is a clean level sampled at the clock edge. The bench drives every input at the falling edge and holds it for a full cycle. It keeps `tick_en` low while reading or writing the counter, except in the scenarios that step the count on purpose, so that every expected count can be worked out exactly. Invalid sizes and misaligned offsets are only ever sent as single isolated requests, so the ignore checks of R6 see an unchanged register file.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned OFS_CAP  = 'h000;
  localparam int unsigned OFS_CFG  = 'h010;
  localparam int unsigned OFS_CNT  = 'h0F0;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_LEG  = 1;

  // Synthesized capabilities word
  function automatic logic [63:0] cap_word(input int unsigned ntim,
                                           input logic [31:0] period_fs,
                                           input logic [15:0] vendor);
    logic [63:0] w;
    w = '0;
    w[7:0]   = 8'd1;
    w[12:8]  = 5'(ntim - 1);
    w[13]    = 1'b0;
    w[31:16] = vendor;
    w[63:32] = period_fs;
    return w;
  endfunction

  // Merge new data into an old word per 32-bit half enable
  function automatic logic [63:0] merge_halves(input logic [63:0] old_w,
                                               input logic [63:0] new_w,
                                               input logic [1:0]  hmask);
    logic [63:0] r;
    r[31:0]  = hmask[0] ? new_w[31:0]  : old_w[31:0];
    r[63:32] = hmask[1] ? new_w[63:32] : old_w[63:32];
    return r;
  endfunction

  // Shape read data for the access width
  function automatic logic [63:0] read_shape(input logic [63:0] w,
                                             input logic wide,
                                             input logic upper);
    if (wide) return w;
    return upper ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
  endfunction
endpackage

// File: rtl/tmr_access_dec.sv
module tmr_access_dec #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [3:0]       req_size,
  input  logic [63:0]      req_wdata,
  output logic             acc_ok,
  output logic             wide,
  output logic             upper,
  output logic             hit_cap,
  output logic             hit_cfg,
  output logic             hit_cnt,
  output logic [1:0]       half_mask,
  output logic [63:0]      wdata_al,
  output logic             wr_cfg,
  output logic             wr_cnt,
  output logic             rd_req
);
  import tmr_pkg::*;
  logic             size_ok, align_ok;
  logic [OFS_W-1:0] base;

  always_comb begin
    size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
    wide     = (req_size == 4'd8);
    align_ok = wide ? (req_offset[2:0] == 3'b000) : (req_offset[1:0] == 2'b00);
    acc_ok   = size_ok && align_ok;
    upper    = !wide && req_offset[2];
    base     = {req_offset[OFS_W-1:3], 3'b000};
    hit_cap  = base == OFS_W'(OFS_CAP);
    hit_cfg  = base == OFS_W'(OFS_CFG);
    hit_cnt  = base == OFS_W'(OFS_CNT);
    half_mask = wide ? 2'b11 : (upper ? 2'b10 : 2'b01);
    wdata_al  = upper ? {req_wdata[31:0], 32'h0} : req_wdata;
    wr_cfg   = req_valid && req_write && acc_ok && hit_cfg;
    wr_cnt   = req_valid && req_write && acc_ok && hit_cnt;
    rd_req   = req_valid && !req_write;
  end
endmodule

// File: rtl/tmr_main_counter.sv
module tmr_main_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        enable,
  input  logic        wr_en,
  input  logic        wr_low,
  input  logic [31:0] wdata_lo,
  output logic [31:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (wr_en) begin
      // zero-extended merge: only the low half can change the count
      if (wr_low)        count <= wdata_lo;
    end
    else if (enable && tick_en) count <= count + 32'd1;
  end
endmodule

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  half_mask,
  input  logic [63:0] wdata,
  input  logic        cnt_wr,
  output logic [63:0] cfg_q,
  output logic        rearm_q
);
  import tmr_pkg::*;
  logic [63:0] cfg_next;

  always_comb begin
    cfg_next = merge_halves(cfg_q, wdata, half_mask);
    cfg_next[BIT_LEG] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rearm_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_next;
      rearm_q <= (wr_en && cfg_next[BIT_EN] && !cfg_q[BIT_EN]) ||
                 (cnt_wr && cfg_q[BIT_EN]);
    end
  end
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top #(
  parameter int unsigned NUM_TIMERS = 8,
  parameter logic [31:0] PERIOD_FS  = 32'd100_000_000,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0C,
  parameter int unsigned OFS_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [3:0]       req_size,
  input  logic [63:0]      req_wdata,
  output logic             rsp_valid,
  output logic [63:0]      rsp_rdata,
  output logic [31:0]      count_o,
  output logic             count_en_o,
  output logic             rearm_o
);
  import tmr_pkg::*;
  localparam logic [63:0] CAP_VAL = cap_word(NUM_TIMERS, PERIOD_FS, VENDOR_ID);

  logic        acc_ok, wide, upper, hit_cap, hit_cfg, hit_cnt;
  logic        wr_cfg, cnt_wr, rd_req;
  logic [1:0]  half_mask;
  logic [63:0] wdata_al, cfg_q, sel_word, rd_next;

  tmr_access_dec #(.OFS_W(OFS_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata), .acc_ok(acc_ok),
    .wide(wide), .upper(upper), .hit_cap(hit_cap), .hit_cfg(hit_cfg),
    .hit_cnt(hit_cnt), .half_mask(half_mask), .wdata_al(wdata_al),
    .wr_cfg(wr_cfg), .wr_cnt(cnt_wr), .rd_req(rd_req)
  );

  tmr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cfg), .half_mask(half_mask),
    .wdata(wdata_al), .cnt_wr(cnt_wr), .cfg_q(cfg_q), .rearm_q(rearm_o)
  );

  tmr_main_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enable(cfg_q[BIT_EN]),
    .wr_en(cnt_wr), .wr_low(half_mask[0]), .wdata_lo(wdata_al[31:0]),
    .count(count_o)
  );

  assign count_en_o = cfg_q[BIT_EN];

  always_comb begin
    if (hit_cap)      sel_word = CAP_VAL;
    else if (hit_cfg) sel_word = cfg_q;
    else if (hit_cnt) sel_word = {32'h0, count_o};
    else              sel_word = '0;
    rd_next = acc_ok ? read_shape(sel_word, wide, upper) : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        req_valid,
  input logic        req_write,
  input logic        acc_ok,
  input logic        cnt_wr,
  input logic [63:0] cfg_q,
  input logic [31:0] count_o,
  input logic        count_en_o,
  input logic        rearm_o,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata
);
  assert_legacy_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[1] == 1'b0);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en_o && !cnt_wr) |=> $stable(count_o));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en_o && tick_en && !cnt_wr) |=> (count_o == $past(count_o) + 32'd1));

  assert_rearm_on_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_en_o) |-> rearm_o);

  assert_bad_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> $stable(cfg_q));

  assert_bad_read_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !acc_ok) |=> (rsp_rdata == 64'hFFFF_FFFF_FFFF_FFFF));

  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_write_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind tick_timer_top tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_write(req_write), .acc_ok(acc_ok), .cnt_wr(cnt_wr), .cfg_q(cfg_q),
  .count_o(count_o), .count_en_o(count_en_o), .rearm_o(rearm_o),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/tick_timer_top_tb_top.sv
`timescale 1ns/1ps
module tick_timer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_offset = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [31:0] count_o;
  logic        count_en_o;
  logic        rearm_o;

  int n_checks = 0;
  int n_fail = 0;
  logic last_rearm;
  logic last_rsp_valid;

  always #2.5 clk = ~clk;

  tick_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .count_o(count_o), .count_en_o(count_en_o), .rearm_o(rearm_o)
  );

  localparam logic [63:0] EXP_CAP = {32'd100_000_000, 16'h1D0C, 3'b000, 5'd7, 8'd1};
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] ofs, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = ofs; req_size = sz; req_wdata = d;
    @(posedge clk); #1;
    last_rearm = rearm_o;
    last_rsp_valid = rsp_valid;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] ofs, input logic [3:0] sz, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = ofs; req_size = sz;
    @(posedge clk); #1;
    d = rsp_rdata;
    last_rsp_valid = rsp_valid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 count after reset", {32'h0, count_o}, 64'h0);
    check("R1 enable after reset", {63'h0, count_en_o}, 64'h0);
    check("R1 rearm after reset", {63'h0, rearm_o}, 64'h0);
    rd(10'h010, 4'd8, d);
    check("R1 config after reset", d, 64'h0);
  endtask

  task automatic t_caps;
    logic [63:0] d;
    rd(10'h000, 4'd8, d);
    check("R2 capabilities 8-byte", d, EXP_CAP);
    check("R11 rsp_valid on read", {63'h0, last_rsp_valid}, 64'h1);
    rd(10'h004, 4'd4, d);
    check("R2 R7 period upper half", d, 64'd100_000_000);
    rd(10'h000, 4'd4, d);
    check("R7 capabilities lower half", d, {32'h0, EXP_CAP[31:0]});
    wr(10'h000, 4'd8, 64'h0123_4567_89AB_CDEF);
    check("R11 no response on write", {63'h0, last_rsp_valid}, 64'h0);
    rd(10'h000, 4'd8, d);
    check("R10 capabilities write ignored", d, EXP_CAP);
  endtask

  task automatic t_config;
    logic [63:0] d;
    wr(10'h010, 4'd8, ONES);
    rd(10'h010, 4'd8, d);
    check("R5 legacy bit reads zero", d, 64'hFFFF_FFFF_FFFF_FFFD);
    wr(10'h010, 4'd8, 64'h0);
    wr(10'h014, 4'd4, 64'h0000_0000_0000_A5A5);
    rd(10'h010, 4'd8, d);
    check("R7 upper-half write only", d, 64'h0000_A5A5_0000_0000);
    wr(10'h010, 4'd4, 64'hFFFF_FFFF_0000_0C02);
    rd(10'h010, 4'd8, d);
    check("R7 lower-half write only, R5", d, 64'h0000_A5A5_0000_0C00);
    rd(10'h014, 4'd4, d);
    check("R7 upper-half read", d, 64'h0000_A5A5);
    wr(10'h010, 4'd8, 64'h0);
  endtask

  task automatic t_invalid;
    logic [63:0] d;
    wr(10'h010, 4'd2, 64'h0000_0000_0000_0F00);
    wr(10'h014, 4'd8, ONES);
    wr(10'h012, 4'd4, ONES);
    rd(10'h010, 4'd8, d);
    check("R6 bad writes ignored", d, 64'h0);
    rd(10'h010, 4'd2, d);
    check("R6 bad size read ones", d, ONES);
    rd(10'h014, 4'd8, d);
    check("R6 misaligned 8-byte read ones", d, ONES);
    rd(10'h012, 4'd4, d);
    check("R6 misaligned 4-byte read ones", d, ONES);
  endtask

  task automatic t_unmapped;
    logic [63:0] d;
    wr(10'h020, 4'd8, ONES);
    rd(10'h020, 4'd8, d);
    check("R9 unmapped read zero", d, 64'h0);
    rd(10'h010, 4'd8, d);
    check("R9 unmapped write no effect on config", d, 64'h0);
    check("R9 unmapped write no effect on count", {32'h0, count_o}, 64'h0);
  endtask

  task automatic t_count;
    logic [63:0] d;
    ticks(4);
    check("R3 disabled count holds", {32'h0, count_o}, 64'h0);
    wr(10'h010, 4'd8, 64'h1);
    check("R4 rearm on enable", {63'h0, last_rearm}, 64'h1);
    ticks(10);
    rd(10'h0F0, 4'd8, d);
    check("R3 R8 count after ten ticks", d, 64'd10);
    wr(10'h010, 4'd8, 64'h0);
    check("R4 no rearm on disable", {63'h0, last_rearm}, 64'h0);
    ticks(7);
    rd(10'h0F0, 4'd4, d);
    check("R4 frozen count", d, 64'd10);
    wr(10'h010, 4'd8, 64'h1);
    ticks(3);
    rd(10'h0F0, 4'd8, d);
    check("R4 resume from frozen value", d, 64'd13);
  endtask

  task automatic t_cnt_write;
    logic [63:0] d;
    wr(10'h0F0, 4'd4, 64'h0000_0000_1234_5678);
    check("R4 rearm on counter write while enabled", {63'h0, last_rearm}, 64'h1);
    rd(10'h0F0, 4'd8, d);
    check("R8 low write sets count", d, 64'h1234_5678);
    wr(10'h0F4, 4'd4, 64'h0000_0000_0000_DEAD);
    rd(10'h0F4, 4'd4, d);
    check("R8 upper counter half reads zero", d, 64'h0);
    rd(10'h0F0, 4'd8, d);
    check("R8 upper write leaves count", d, 64'h1234_5678);
    wr(10'h0F0, 4'd8, 64'hABCD_0000_FFFF_FFFF);
    ticks(1);
    check("R3 wrap to zero", {32'h0, count_o}, 64'h0);
    wr(10'h010, 4'd8, 64'h0);
    wr(10'h0F0, 4'd8, 64'h55);
    check("R4 no rearm on counter write while disabled", {63'h0, last_rearm}, 64'h0);
    check("R8 write while disabled", {32'h0, count_o}, 64'h55);
  endtask

  initial begin
    last_rearm = 1'b0;
    last_rsp_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_caps();
    t_config();
    t_invalid();
    t_unmapped();
    t_count();
    t_cnt_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule